// File: doc/BRIEF.md
# Event-to-Host Interrupt Mapping Controller

This block gathers a set of system event lines and turns them into a smaller set of host interrupt lines. Each event has a pending latch that can be level-following or edge-capturing, with a selectable active level, plus an enable bit. An enabled pending event is routed in two steps: first to a channel, chosen by a 4-bit field per event, then to a host, chosen by a 4-bit field per channel. A host line is raised when the global enable and that host's own enable are both set and at least one live event reaches it.

Software reaches the block through a plain 32-bit word read/write port with byte addresses. Pending and enable state can be changed either by writing an event number to an indexed register or by writing a bitmap with 32 events per word. Each host also has a read-only word that reports the winning event under a fixed priority rule, or a flag when nothing is live for that host. A read returns its data on the clock edge that samples `rd_en`. A write takes effect on the clock edge that samples `wr_en`.

Top module: `evhost_intc`

## Requirements
- R1: After reset the host lines are low, the global enable (0x000 bit 0), all event enables and all host enables are 0, and every channel-map and host-map word reads 0. The polarity words (0x200 + 4*w) read 1 for each implemented event and 0 above it, the type words (0x240 + 4*w) read 0, and every priority word reads 0x8000_0000.
- R2: The channel-map word at 0x400 + 4*(e/4) holds event e's channel in bits (e%4)*8 +: 4. The other bits of each byte read 0. Writing a word updates the four events it covers.
- R3: The host-map word at 0x500 + 4*(c/4) holds channel c's host in bits (c%4)*8 +: 4. The other bits read 0, and fields for channels that are not implemented read 0.
- R4: For an edge-type event, writing e to 0x004 makes it pending and writing e to 0x008 clears its pending latch. The event number is taken from wdata bits 9:0.
- R5: Writing e to 0x00C enables event e and writing e to 0x010 disables it. A 1 in bit e%32 of word e/32 sets the enable at 0x180 + 4*w and clears it at 0x1C0 + 4*w. Both ranges read back the enables.
- R6: The word at 0x100 + 4*w reads pending state, with event e in bit e%32 of word e/32. Writing a 1 to a bit clears that pending latch, and a 0 leaves it untouched.
- R7: Writing h to 0x014 enables host h and writing h to 0x018 disables it. Both addresses read the host enables with host h in bit h. A disabled host line stays low.
- R8: While bit 0 of 0x000 is 0, every host line is low.
- R9: Type bit 0 (level) makes the pending state follow the event's active level, with polarity bit 1 meaning active-high and 0 meaning active-low. Status set and clear writes do not change a level-type event.
- R10: Type bit 1 (edge) latches pending on a transition into the active level. The latch holds after the input goes inactive, until it is cleared, and a held level does not re-latch it.
- R11: The word at 0x600 + 4*h reads 0x8000_0000 when no enabled pending event is routed to host h. Otherwise it returns the winning event number in bits 9:0 and 0 elsewhere. The lowest channel wins first, then the lowest event within that channel.
- R12: Host line h rises one cycle after the global enable, host h's enable and at least one enabled pending event routed to h are all present. It falls when any of them goes away, and events routed to other hosts do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_EVT | System event lines |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port |
| addr | input | 12 | Byte address of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| host_irq | output | NUM_HOST | Host interrupt lines, registered |

## Verification
The bench builds the block with 40 events, 6 channels and 4 hosts. With 40 events, the second pending, enable, polarity and type words are only partly filled, so reads of bits with no event behind them can be checked. With 6 channels, the second host-map word holds two live fields and two absent ones. Four hosts are enough to show that an event can be steered away from host 0 onto another line, and that a host with no routed events stays silent. The priority word is walked down a chain of events spread over three channels, so that both the channel order and the event order inside a channel decide the result.

// File: rtl/evhost_pkg.sv
`timescale 1ns/1ps
package evhost_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned MAP_W   = 4;
  localparam int unsigned IDX_W   = 10;

  localparam logic [ADDR_W-1:0] A_GEN     = 12'h000;
  localparam logic [ADDR_W-1:0] A_SET_IDX = 12'h004;
  localparam logic [ADDR_W-1:0] A_CLR_IDX = 12'h008;
  localparam logic [ADDR_W-1:0] A_ENS_IDX = 12'h00C;
  localparam logic [ADDR_W-1:0] A_ENC_IDX = 12'h010;
  localparam logic [ADDR_W-1:0] A_HES_IDX = 12'h014;
  localparam logic [ADDR_W-1:0] A_HEC_IDX = 12'h018;
  localparam logic [ADDR_W-1:0] A_RAW     = 12'h100;
  localparam logic [ADDR_W-1:0] A_ENS     = 12'h180;
  localparam logic [ADDR_W-1:0] A_ENC     = 12'h1C0;
  localparam logic [ADDR_W-1:0] A_POL     = 12'h200;
  localparam logic [ADDR_W-1:0] A_TYP     = 12'h240;
  localparam logic [ADDR_W-1:0] A_CMAP    = 12'h400;
  localparam logic [ADDR_W-1:0] A_HMAP    = 12'h500;
  localparam logic [ADDR_W-1:0] A_PIDX    = 12'h600;

  localparam logic [31:0] PIDX_NONE = 32'h8000_0000;

  // byte address of word w in a region starting at base
  function automatic logic [ADDR_W-1:0] woff(input logic [ADDR_W-1:0] base, input int w);
    return base + ADDR_W'(w * 4);
  endfunction
endpackage

// File: rtl/evhost_latch.sv
`timescale 1ns/1ps
module evhost_latch #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_in,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] typ,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] pend
);
  logic [N-1:0] act_q;
  logic [N-1:0] act_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      act_d <= '0;
      pend  <= '0;
    end else begin
      act_q <= ~(evt_in ^ pol);
      act_d <= act_q;
      for (int e = 0; e < N; e++) begin
        if (typ[e])
          pend[e] <= (pend[e] & ~clr_req[e]) | set_req[e] | (act_q[e] & ~act_d[e]);
        else
          pend[e] <= act_q[e];
      end
    end
  end
endmodule

// File: rtl/evhost_resolve.sv
`timescale 1ns/1ps
module evhost_resolve #(
  parameter int unsigned N   = 64,
  parameter int unsigned NCH = 10,
  parameter int unsigned NH  = 10,
  parameter int unsigned MW  = 4,
  parameter int unsigned IW  = 10
) (
  input  logic [N-1:0]            live,
  input  logic [N-1:0][MW-1:0]    cmap,
  input  logic [NCH-1:0][MW-1:0]  hmap,
  output logic [NH-1:0]           hit,
  output logic [NH-1:0][IW-1:0]   win
);
  logic [NCH-1:0]         ch_any;
  logic [NCH-1:0][IW-1:0] ch_idx;

  always_comb begin
    ch_any = '0;
    ch_idx = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int e = N - 1; e >= 0; e--) begin
        if (live[e] && cmap[e] == MW'(c)) begin
          ch_any[c] = 1'b1;
          ch_idx[c] = IW'(e);
        end
      end
    end
  end

  always_comb begin
    hit = '0;
    win = '0;
    for (int h = 0; h < NH; h++) begin
      for (int c = NCH - 1; c >= 0; c--) begin
        if (ch_any[c] && hmap[c] == MW'(h)) begin
          hit[h] = 1'b1;
          win[h] = ch_idx[c];
        end
      end
    end
  end
endmodule

// File: rtl/evhost_intc.sv
`timescale 1ns/1ps
module evhost_intc
  import evhost_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 64,
  parameter int unsigned NUM_CH   = 10,
  parameter int unsigned NUM_HOST = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EVT-1:0]  evt_in,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [11:0]         addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [NUM_HOST-1:0] host_irq
);
  logic                           gen_q;
  logic [NUM_EVT-1:0]             en_q, pol_q, typ_q, pend;
  logic [NUM_HOST-1:0]            hen_q;
  logic [NUM_EVT-1:0][MAP_W-1:0]  cmap_q;
  logic [NUM_CH-1:0][MAP_W-1:0]   hmap_q;
  logic [NUM_EVT-1:0]             st_set, st_clr, en_set, en_clr, live;
  logic [NUM_HOST-1:0]            hs_set, hs_clr, hit;
  logic [NUM_HOST-1:0][IDX_W-1:0] win;
  logic [31:0]                    rd_mux;

  always_comb begin
    for (int e = 0; e < NUM_EVT; e++) begin
      st_set[e] = wr_en && addr == A_SET_IDX && wdata[IDX_W-1:0] == IDX_W'(e);
      st_clr[e] = wr_en && ((addr == A_CLR_IDX && wdata[IDX_W-1:0] == IDX_W'(e)) ||
                            (addr == woff(A_RAW, e / 32) && wdata[e % 32]));
      en_set[e] = wr_en && ((addr == A_ENS_IDX && wdata[IDX_W-1:0] == IDX_W'(e)) ||
                            (addr == woff(A_ENS, e / 32) && wdata[e % 32]));
      en_clr[e] = wr_en && ((addr == A_ENC_IDX && wdata[IDX_W-1:0] == IDX_W'(e)) ||
                            (addr == woff(A_ENC, e / 32) && wdata[e % 32]));
    end
    for (int h = 0; h < NUM_HOST; h++) begin
      hs_set[h] = wr_en && addr == A_HES_IDX && wdata[IDX_W-1:0] == IDX_W'(h);
      hs_clr[h] = wr_en && addr == A_HEC_IDX && wdata[IDX_W-1:0] == IDX_W'(h);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q  <= 1'b0;
      en_q   <= '0;
      hen_q  <= '0;
      pol_q  <= '1;
      typ_q  <= '0;
      cmap_q <= '0;
      hmap_q <= '0;
    end else begin
      en_q  <= (en_q & ~en_clr) | en_set;
      hen_q <= (hen_q & ~hs_clr) | hs_set;
      if (wr_en && addr == A_GEN) gen_q <= wdata[0];
      for (int e = 0; e < NUM_EVT; e++) begin
        if (wr_en && addr == woff(A_POL, e / 32)) pol_q[e] <= wdata[e % 32];
        if (wr_en && addr == woff(A_TYP, e / 32)) typ_q[e] <= wdata[e % 32];
        if (wr_en && addr == woff(A_CMAP, e / 4)) cmap_q[e] <= wdata[(e % 4) * 8 +: MAP_W];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_en && addr == woff(A_HMAP, c / 4)) hmap_q[c] <= wdata[(c % 4) * 8 +: MAP_W];
      end
    end
  end

  evhost_latch #(.N(NUM_EVT)) u_latch (
    .clk(clk), .rst(rst), .evt_in(evt_in), .pol(pol_q), .typ(typ_q),
    .set_req(st_set), .clr_req(st_clr), .pend(pend)
  );

  assign live = pend & en_q;

  evhost_resolve #(
    .N(NUM_EVT), .NCH(NUM_CH), .NH(NUM_HOST), .MW(MAP_W), .IW(IDX_W)
  ) u_resolve (
    .live(live), .cmap(cmap_q), .hmap(hmap_q), .hit(hit), .win(win)
  );

  always_comb begin
    rd_mux = '0;
    if (addr == A_GEN) rd_mux[0] = gen_q;
    if (addr == A_HES_IDX || addr == A_HEC_IDX) rd_mux[NUM_HOST-1:0] = hen_q;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (addr == woff(A_RAW, e / 32)) rd_mux[e % 32] = pend[e];
      if (addr == woff(A_ENS, e / 32) || addr == woff(A_ENC, e / 32)) rd_mux[e % 32] = en_q[e];
      if (addr == woff(A_POL, e / 32)) rd_mux[e % 32] = pol_q[e];
      if (addr == woff(A_TYP, e / 32)) rd_mux[e % 32] = typ_q[e];
      if (addr == woff(A_CMAP, e / 4)) rd_mux[(e % 4) * 8 +: MAP_W] = cmap_q[e];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == woff(A_HMAP, c / 4)) rd_mux[(c % 4) * 8 +: MAP_W] = hmap_q[c];
    end
    for (int h = 0; h < NUM_HOST; h++) begin
      if (addr == woff(A_PIDX, h))
        rd_mux = hit[h] ? {{(32 - IDX_W){1'b0}}, win[h]} : PIDX_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      host_irq <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      host_irq <= {NUM_HOST{gen_q}} & hen_q & hit;
    end
  end
endmodule

// File: rtl/evhost_intc_chk.sv
`timescale 1ns/1ps
module evhost_intc_chk #(
  parameter int unsigned N  = 64,
  parameter int unsigned NH = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          gen_q,
  input logic [NH-1:0] hen_q,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  typ_q,
  input logic [N-1:0]  st_clr,
  input logic [N-1:0]  live,
  input logic [NH-1:0] host_irq
);
  // R8
  gen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !gen_q |=> (host_irq == '0));

  // R7
  hen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((host_irq & ~$past(hen_q)) == '0));

  // R12
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    (live == '0) |=> (host_irq == '0));

  // R10
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(pend & typ_q & ~st_clr) & ~pend) == '0));
endmodule

bind evhost_intc evhost_intc_chk #(.N(NUM_EVT), .NH(NUM_HOST)) u_chk (
  .clk(clk), .rst(rst), .gen_q(gen_q), .hen_q(hen_q), .pend(pend),
  .typ_q(typ_q), .st_clr(st_clr), .live(live), .host_irq(host_irq)
);

// File: tb/evhost_intc_tb.sv
`timescale 1ns/1ps
module evhost_intc_tb;
  localparam int NE = 40;
  localparam int NC = 6;
  localparam int NH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] evt_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NH-1:0] host_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evhost_intc #(.NUM_EVT(NE), .NUM_CH(NC), .NUM_HOST(NH)) u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 host lines", 32'(host_irq), 32'h0);
    rd(12'h000, v); chk("R1 global enable", v, 32'h0);
    rd(12'h014, v); chk("R1 host enables", v, 32'h0);
    rd(12'h180, v); chk("R1 event enables", v, 32'h0);
    rd(12'h400, v); chk("R1 channel map", v, 32'h0);
    rd(12'h504, v); chk("R1 host map", v, 32'h0);
    rd(12'h200, v); chk("R1 polarity w0", v, 32'hFFFF_FFFF);
    rd(12'h204, v); chk("R1 polarity w1", v, 32'h0000_00FF);
    rd(12'h240, v); chk("R1 type w0", v, 32'h0);
    rd(12'h600, v); chk("R1 prio h0", v, 32'h8000_0000);
    rd(12'h60C, v); chk("R1 prio h3", v, 32'h8000_0000);
  endtask

  task automatic t_maps;
    logic [31:0] v;
    wr(12'h404, 32'hABCD_EF12);
    rd(12'h404, v); chk("R2 channel map fields", v, 32'h0B0D_0F02);
    rd(12'h400, v); chk("R2 neighbour word", v, 32'h0);
    wr(12'h504, 32'h3322_1100);
    rd(12'h504, v); chk("R3 host map fields", v, 32'h0000_0100);
    wr(12'h404, 32'h0);
    wr(12'h504, 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(12'h240, 32'hFFFF_FFFF);
    wr(12'h244, 32'h0000_00FF);
    waitc(3);
    wr(12'h004, 32'd5);
    rd(12'h100, v); chk("R4 index set", v, 32'h0000_0020);
    wr(12'h008, 32'd5);
    rd(12'h100, v); chk("R4 index clear", v, 32'h0);
    wr(12'h004, 32'd3);
    wr(12'h004, 32'd33);
    rd(12'h104, v); chk("R6 raw word1", v, 32'h0000_0002);
    wr(12'h100, 32'h0000_0008);
    rd(12'h100, v); chk("R6 bitmap clear w0", v, 32'h0);
    rd(12'h104, v); chk("R6 other word kept", v, 32'h0000_0002);
    wr(12'h104, 32'h0000_0002);
    rd(12'h104, v); chk("R6 bitmap clear w1", v, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(12'h00C, 32'd7);
    rd(12'h180, v); chk("R5 index enable", v, 32'h0000_0080);
    wr(12'h184, 32'h0000_0005);
    rd(12'h1C4, v); chk("R5 bitmap enable", v, 32'h0000_0005);
    wr(12'h1C4, 32'h0000_0001);
    rd(12'h184, v); chk("R5 bitmap disable", v, 32'h0000_0004);
    wr(12'h010, 32'd7);
    rd(12'h180, v); chk("R5 index disable", v, 32'h0);
    wr(12'h010, 32'd34);
  endtask

  task automatic t_output;
    logic [31:0] v;
    wr(12'h00C, 32'd2);
    wr(12'h004, 32'd2);
    waitc(3); chk("R8 global off", 32'(host_irq), 32'h0);
    wr(12'h000, 32'h1);
    waitc(3); chk("R7 host off", 32'(host_irq), 32'h0);
    wr(12'h014, 32'd0);
    waitc(3); chk("R12 host0 raised", 32'(host_irq), 32'h1);
    rd(12'h018, v); chk("R7 host enable readback", v, 32'h1);
    wr(12'h018, 32'd0);
    waitc(3); chk("R7 host disabled", 32'(host_irq), 32'h0);
    wr(12'h014, 32'd0);
    wr(12'h000, 32'h0);
    waitc(3); chk("R8 global cleared", 32'(host_irq), 32'h0);
    wr(12'h000, 32'h1);
    waitc(3); chk("R8 global restored", 32'(host_irq), 32'h1);
    wr(12'h400, 32'h0003_0000);
    wr(12'h500, 32'h0200_0000);
    wr(12'h014, 32'd2);
    waitc(3); chk("R12 rerouted to host2", 32'(host_irq), 32'h4);
    wr(12'h008, 32'd2);
    waitc(3); chk("R12 cleared event", 32'(host_irq), 32'h0);
    wr(12'h400, 32'h0);
    wr(12'h500, 32'h0);
    wr(12'h010, 32'd2);
  endtask

  task automatic t_prio;
    logic [31:0] v;
    wr(12'h408, 32'h0002_0000);
    wr(12'h414, 32'h0000_0001);
    wr(12'h418, 32'h0000_0100);
    wr(12'h41C, 32'h0004_0000);
    wr(12'h500, 32'h0001_0100);
    wr(12'h504, 32'h0000_0001);
    wr(12'h180, 32'h4210_0400);
    wr(12'h004, 32'd30);
    wr(12'h004, 32'd25);
    wr(12'h004, 32'd10);
    wr(12'h004, 32'd20);
    rd(12'h604, v); chk("R11 lowest channel first", v, 32'd20);
    wr(12'h008, 32'd20);
    rd(12'h604, v); chk("R11 next event same channel", v, 32'd25);
    wr(12'h008, 32'd25);
    rd(12'h604, v); chk("R11 channel 2", v, 32'd10);
    wr(12'h008, 32'd10);
    rd(12'h604, v); chk("R11 channel 4", v, 32'd30);
    rd(12'h600, v); chk("R11 other host none", v, 32'h8000_0000);
    wr(12'h008, 32'd30);
    rd(12'h604, v); chk("R11 none", v, 32'h8000_0000);
    wr(12'h010, 32'd30);
    wr(12'h004, 32'd30);
    rd(12'h604, v); chk("R11 disabled pending", v, 32'h8000_0000);
    wr(12'h008, 32'd30);
    wr(12'h1C0, 32'hFFFF_FFFF);
    wr(12'h408, 32'h0); wr(12'h414, 32'h0); wr(12'h418, 32'h0); wr(12'h41C, 32'h0);
    wr(12'h500, 32'h0); wr(12'h504, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(12'h240, 32'hFFFF_FFEF);
    waitc(2);
    evt_in[4] = 1'b1;
    waitc(4);
    rd(12'h100, v); chk("R9 level follows high", v, 32'h0000_0010);
    wr(12'h008, 32'd4);
    rd(12'h100, v); chk("R9 clear ignored", v, 32'h0000_0010);
    evt_in[4] = 1'b0;
    waitc(4);
    rd(12'h100, v); chk("R9 level follows low", v, 32'h0);
    wr(12'h004, 32'd4);
    rd(12'h100, v); chk("R9 set ignored", v, 32'h0);
    wr(12'h200, 32'hFFFF_FFEF);
    waitc(4);
    rd(12'h100, v); chk("R9 active low", v, 32'h0000_0010);
    wr(12'h200, 32'hFFFF_FFFF);
    waitc(4);
    rd(12'h100, v); chk("R9 polarity restored", v, 32'h0);
    wr(12'h240, 32'hFFFF_FFFF);
    waitc(3);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    evt_in[36] = 1'b1;
    waitc(4);
    evt_in[36] = 1'b0;
    waitc(4);
    rd(12'h104, v); chk("R10 edge latched", v, 32'h0000_0010);
    wr(12'h104, 32'h0000_0010);
    waitc(3);
    rd(12'h104, v); chk("R10 cleared stays low", v, 32'h0);
    evt_in[36] = 1'b1;
    waitc(4);
    rd(12'h104, v); chk("R10 second edge", v, 32'h0000_0010);
    wr(12'h008, 32'd36);
    waitc(3);
    rd(12'h104, v); chk("R10 held level no relatch", v, 32'h0);
    evt_in[36] = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    waitc(2);
    t_reset();
    t_maps();
    t_status();
    t_enable();
    t_output();
    t_prio();
    t_level();
    t_edge();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1-related run hung got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule